// File: doc/BRIEF.md
# Paged Byte Store with Timed Commit

This block is the storage side of a small serial byte memory. It keeps a 256-byte array, a 16-slot staging buffer for one page, a single address pointer shared by reads and writes, and a countdown that models the time a program cycle takes. A protocol front end drives it one command per clock: set the pointer, stage a byte, fetch a byte, or commit the staged page.

Staged writes stay inside the 16-byte page the pointer sits in. The low four pointer bits step and wrap, and the upper four stay put. Reads walk the whole 8-bit space. On commit, the slots that actually received data are copied into the array in one clock. The block then reports busy for a fixed number of cycles and refuses work until that time has passed.

Top module: `page_store`

## Requirements
- R1: After reset, busy_o, err_o and rvalid_o are 0, the pointer is 0 and every array byte reads 0.
- R2: A load sets the pointer to data_i. A read returns the array byte at the pointer on rdata_o with rvalid_o high in the cycle after the request. rvalid_o is high for that one cycle only.
- R3: Each accepted read adds one to the full 8-bit pointer, so address 255 is followed by address 0.
- R4: An accepted write stages data_i in slot pointer[3:0] and adds one to pointer[3:0] only, so slot 15 is followed by slot 0 of the same page. A later write to a slot replaces the earlier byte.
- R5: A commit copies only the slots written since the last load or commit into array address {pointer[7:4], slot}. All other bytes of the page keep their contents.
- R6: A commit with at least one staged byte raises busy_o in the next cycle and holds it for exactly WR_CYCLES cycles.
- R7: A commit with no staged byte leaves busy_o low.
- R8: A load discards every byte staged before it.
- R9: While busy_o is high, every command is dropped. A write or read request sets err_o for the following cycle and produces no rvalid_o. Load and commit requests are dropped without a flag.
- R10: The pointer keeps its value between transfers. A read issued without a load starts at the position following the last byte written or read.
- R11: When several command inputs are high together, only one is taken, in the order load, write, read, commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Set the pointer to data_i |
| write_i | input | 1 | Stage data_i at the pointer |
| read_i | input | 1 | Fetch the byte at the pointer |
| commit_i | input | 1 | Program the staged bytes |
| data_i | input | 8 | Address for load, byte for write |
| rdata_o | output | 8 | Fetched byte |
| rvalid_o | output | 1 | rdata_o holds a fresh byte |
| busy_o | output | 1 | Program cycle in progress |
| err_o | output | 1 | Request refused while busy |

## Verification
rdata_o, rvalid_o and err_o each come from a single register, so each is due exactly one edge after its request. The bench drives a command for one edge and samples at the falling edge that follows. busy_o also rises one edge after a commit. The bench counts the falling edges at which busy_o is high and compares that count with WR_CYCLES. Commands issued while busy_o is high are judged at the same falling edge, and their lack of effect is shown later through reads and an empty commit.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;
  parameter int SLOT_W = 4;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef enum logic [2:0] {OP_NONE, OP_LOAD, OP_WRITE, OP_READ, OP_COMMIT} op_e;

  // staging step: low slot bits roll over, page bits held
  function automatic addr_t wr_advance(input addr_t p);
    logic [SLOT_W-1:0] s;
    s = p[SLOT_W-1:0] + SLOT_W'(1);
    return {p[ADDR_W-1:SLOT_W], s};
  endfunction

  // fetch step: whole pointer rolls over
  function automatic addr_t rd_advance(input addr_t p);
    return p + ADDR_W'(1);
  endfunction

  function automatic op_e pick_op(input logic ld, input logic wr, input logic rd, input logic cm);
    if (ld)      return OP_LOAD;
    else if (wr) return OP_WRITE;
    else if (rd) return OP_READ;
    else if (cm) return OP_COMMIT;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr
  import pgbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_load,
  input  logic  ev_write,
  input  logic  ev_read,
  input  addr_t load_val,
  output addr_t ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ev_load)  ptr <= load_val;
    else if (ev_write) ptr <= wr_advance(ptr);
    else if (ev_read)  ptr <= rd_advance(ptr);
  end

  assert_page_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> ptr[ADDR_W-1:SLOT_W] == $past(ptr[ADDR_W-1:SLOT_W]));
  assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && ptr[SLOT_W-1:0] == '1) |=> ptr[SLOT_W-1:0] == '0);
  assert_read_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read && ptr == '1) |=> ptr == '0);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_load || ev_write || ev_read) |=> $stable(ptr));
endmodule

// File: rtl/pgbuf_page.sv
module pgbuf_page
  import pgbuf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_load,
  input  logic                         ev_write,
  input  logic                         ev_commit,
  input  logic [SLOT_W-1:0]            slot,
  input  data_t                        wdata,
  output logic [SLOTS-1:0][DATA_W-1:0] slot_q,
  output logic [SLOTS-1:0]             mask_q
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    wire hit = ev_write && (slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else begin
        if (hit) slot_q[g] <= wdata;
        if (ev_load || ev_commit) mask_q[g] <= 1'b0;
        else if (hit)             mask_q[g] <= 1'b1;
      end
    end
  end

  assert_load_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> mask_q == '0);
  assert_write_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> mask_q[$past(slot)] && slot_q[$past(slot)] == $past(wdata));
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int WR_CYCLES = 20,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (start)    cnt <= CNT_W'(WR_CYCLES);
    else if (cnt != 0) cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_quiet_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/page_store.sv
module page_store
  import pgbuf_pkg::*;
#(
  parameter int WR_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       write_i,
  input  logic       read_i,
  input  logic       commit_i,
  input  logic [7:0] data_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o,
  output logic       busy_o,
  output logic       err_o
);
  op_e   op;
  addr_t ptr;
  logic [SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [SLOTS-1:0] mask_q;
  data_t mem [DEPTH];

  assign op = pick_op(load_i, write_i, read_i, commit_i);

  // named internal events
  wire ev_load   = !busy_o && (op == OP_LOAD);
  wire ev_write  = !busy_o && (op == OP_WRITE);
  wire ev_read   = !busy_o && (op == OP_READ);
  wire ev_commit = !busy_o && (op == OP_COMMIT);
  wire ev_start  = ev_commit && (mask_q != '0);
  wire ev_reject = busy_o && (op == OP_WRITE || op == OP_READ);

  pgbuf_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_write(ev_write),
    .ev_read(ev_read), .load_val(data_i), .ptr(ptr)
  );

  pgbuf_page u_page (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_write(ev_write),
    .ev_commit(ev_commit), .slot(ptr[SLOT_W-1:0]), .wdata(data_i),
    .slot_q(slot_q), .mask_q(mask_q)
  );

  pgbuf_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .busy(busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (ev_start) begin
      for (int s = 0; s < SLOTS; s++)
        if (mask_q[s]) mem[{ptr[ADDR_W-1:SLOT_W], SLOT_W'(s)}] <= slot_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= ev_read;
      err_o    <= ev_reject;
      if (ev_read) rdata_o <= mem[ptr];
    end
  end

  assert_reject_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> err_o && !rvalid_o);
  assert_busy_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !rvalid_o);
  assert_empty_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && mask_q == '0) |=> !busy_o);
  assert_one_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_load, ev_write, ev_read, ev_commit}) <= 1);
  assert_fetch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_read |=> !rvalid_o);
endmodule

// File: tb/tb_page_store.sv
module tb_page_store;
  localparam int WR = 20;
  localparam logic [1:0] V_LD = 2'd0, V_WR = 2'd1, V_RD = 2'd2, V_CM = 2'd3;
  localparam int NV = 21;
  // {op, data, expected read byte}
  localparam logic [17:0] VEC [NV] = '{
    {V_LD, 8'h10, 8'h00}, {V_WR, 8'h11, 8'h00}, {V_WR, 8'h22, 8'h00},
    {V_WR, 8'h33, 8'h00}, {V_CM, 8'h00, 8'h00}, {V_LD, 8'h0F, 8'h00},
    {V_RD, 8'h00, 8'h00}, {V_RD, 8'h00, 8'h11}, {V_RD, 8'h00, 8'h22},
    {V_RD, 8'h00, 8'h33}, {V_RD, 8'h00, 8'h00}, {V_LD, 8'h3E, 8'h00},
    {V_WR, 8'h5A, 8'h00}, {V_WR, 8'h6B, 8'h00}, {V_WR, 8'h7C, 8'h00},
    {V_CM, 8'h00, 8'h00}, {V_LD, 8'h3F, 8'h00}, {V_RD, 8'h00, 8'h6B},
    {V_RD, 8'h00, 8'h00}, {V_LD, 8'h30, 8'h00}, {V_RD, 8'h00, 8'h7C}
  };

  logic clk = 0, rst_n = 0;
  logic load_i = 0, write_i = 0, read_i = 0, commit_i = 0;
  logic [7:0] data_i = 0;
  logic [7:0] rdata_o;
  logic rvalid_o, busy_o, err_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  page_store #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .write_i(write_i), .read_i(read_i),
    .commit_i(commit_i), .data_i(data_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic l, input logic w, input logic r, input logic c, input logic [7:0] d);
    load_i = l; write_i = w; read_i = r; commit_i = c; data_i = d;
    @(posedge clk);
    @(negedge clk);
    load_i = 0; write_i = 0; read_i = 0; commit_i = 0;
  endtask

  task automatic load(input logic [7:0] a);  issue(1, 0, 0, 0, a); endtask
  task automatic put(input logic [7:0] d);   issue(0, 1, 0, 0, d); endtask
  task automatic commit();                   issue(0, 0, 0, 1, 0); endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fetch(input string req, input logic [7:0] exp);
    issue(0, 0, 1, 0, 0);
    check({req, " rvalid"}, rvalid_o, 1);
    check({req, " rdata"}, rdata_o, exp);
  endtask

  task automatic commit_wait();
    int n;
    commit();
    wait_idle(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy_o, 0);
    check("R1 err", err_o, 0);
    check("R1 rvalid", rvalid_o, 0);
    rst_n = 1;
    @(negedge clk);
    fetch("R1 addr0", 8'h00);
    // R2: rvalid lasts one cycle
    @(negedge clk);
    check("R2 rvalid drop", rvalid_o, 0);

    // table walk (R2 R3 R4 R5 R10)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        V_LD: load(VEC[i][15:8]);
        V_WR: put(VEC[i][15:8]);
        V_RD: fetch($sformatf("R2 vec%0d", i), VEC[i][7:0]);
        default: commit_wait();
      endcase
    end

    // R3: read across 255 -> 0
    load(8'hFF); put(8'hE1); commit_wait();
    load(8'h00); put(8'hD2); commit_wait();
    load(8'hFF);
    fetch("R3 at FF", 8'hE1);
    fetch("R3 wrap 00", 8'hD2);

    // R10: pointer retained after a write
    load(8'h56); put(8'h77); commit_wait();
    load(8'h55); put(8'h99); commit_wait();
    fetch("R10 next after write", 8'h77);

    // R4 + R6: seventeen writes, slot 0 overwritten; busy length
    load(8'h80);
    for (int k = 0; k < 17; k++) put(8'h40 + 8'(k));
    commit();
    check("R6 busy rise", busy_o, 1);
    wait_idle(n);
    check("R6 busy cycles", n, WR);
    load(8'h80);
    fetch("R4 overwrite slot0", 8'h50);
    fetch("R4 slot1", 8'h41);

    // R5: only written slots programmed
    load(8'h12); put(8'hEE); commit_wait();
    load(8'h10);
    fetch("R5 keep 10", 8'h11);
    fetch("R5 keep 11", 8'h22);
    fetch("R5 new 12", 8'hEE);
    fetch("R5 keep 13", 8'h00);

    // R7: empty commit
    load(8'h20); commit();
    check("R7 no busy", busy_o, 0);

    // R8: load discards staged bytes
    load(8'h60); put(8'hAB); load(8'h61); put(8'hCD); commit_wait();
    load(8'h60);
    fetch("R8 dropped", 8'h00);
    fetch("R8 kept", 8'hCD);

    // R9: requests during busy
    load(8'h90); put(8'h01); commit();
    issue(0, 0, 1, 0, 0);
    check("R9 read err", err_o, 1);
    check("R9 read no data", rvalid_o, 0);
    @(negedge clk);
    check("R9 err one cycle", err_o, 0);
    put(8'hFF);
    check("R9 write err", err_o, 1);
    load(8'h00);
    check("R9 load silent", err_o, 0);
    wait_idle(n);
    commit();
    check("R9 write dropped", busy_o, 0);
    fetch("R9 load dropped", 8'h00);
    load(8'h90);
    fetch("R9 data kept", 8'h01);

    // R11: priority
    issue(1, 0, 1, 0, 8'h12);
    check("R11 load over read", rvalid_o, 0);
    fetch("R11 loaded addr", 8'hEE);
    load(8'hA0);
    issue(0, 1, 1, 0, 8'h3C);
    check("R11 write over read", rvalid_o, 0);
    commit_wait();
    load(8'hA0);
    fetch("R11 write landed", 8'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule